// File: doc/BRIEF.md
# Tagged Read Reorder Buffer

This block sits between a read-response path that returns cache lines in any order and a consumer that has to see them in the order the reads were issued. When a read is issued, the issuer presents its stream number and request id. The block reserves the next slot of a circular buffer and hands back that slot's index, which the issuer uses as the read tag.

Each response brings back a tag and a whole 1024-bit line. The line is written into the matching slot, which is then marked complete. A response may also carry an error indication. The oldest slot leaves the buffer only once its line is present, and it leaves with the stream number and request id it was given. A full flag tells the issuer to stop while every slot is reserved.

Responses whose tag does not name a slot that is waiting for data are discarded. Each such response sets a protocol-error bit that stays set until reset.

Top module: `rrb_reorder_buf`

## Requirements
- R1: After reset, out_valid, full and proto_err are 0 and alloc_tag is 0.
- R2: A request is accepted on a clock edge where alloc_valid is 1 and full is 0. Each accepted request is given the tag shown on alloc_tag before that edge. After the edge, alloc_tag advances by one, wrapping from DEPTH-1 to 0.
- R3: full is 1 exactly while DEPTH requests are outstanding, counting from acceptance to delivery. While full is 1, alloc_valid is ignored and alloc_tag does not change.
- R4: Beats leave on out_valid in the order in which their requests were accepted, whatever order the responses arrive in.
- R5: A delivered beat carries on out_data the line written by the response for its tag. It carries on out_stream and out_id the values given at acceptance. When that slot is the oldest outstanding one, out_valid is 1 in the cycle after the edge that took the response.
- R6: A response for a slot that is not the oldest outstanding one produces no beat until every older slot has been delivered.
- R7: At most one beat is delivered per cycle. Completed slots waiting at the head are delivered on consecutive cycles.
- R8: A response taken with rsp_err = 1 still delivers in order, with out_err = 1. Otherwise out_err is 0.
- R9: A response whose tag is free, or already holds data, is dropped: it changes no slot and produces no beat. It sets proto_err one edge later, and proto_err then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issuer requests a slot for a new read |
| alloc_stream | input | STREAM_W | Stream number stored with the slot |
| alloc_id | input | ID_W | Request id stored with the slot |
| alloc_tag | output | TAG_W | Tag the next accepted request receives |
| full | output | 1 | All slots reserved; requests are refused |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_err | input | 1 | Response reports a failed read |
| rsp_data | input | DATA_W | Cache line returned |
| out_valid | output | 1 | Ordered beat present |
| out_stream | output | STREAM_W | Stream number of the beat |
| out_id | output | ID_W | Request id of the beat |
| out_err | output | 1 | Beat comes from a failed read |
| out_data | output | DATA_W | Cache line of the beat |
| proto_err | output | 1 | Sticky: a response named a slot not waiting for data |

## Verification
alloc_tag and full take their new value at the edge that accepts or delivers. proto_err rises at the edge that takes the offending response. A beat appears one edge after its slot is both complete and oldest, so a response to the head shows on out_valid two falling edges after it is driven. The bench drives on the falling edge, and a behavioural model advances on the rising edge from the inputs seen there. Every output is compared with the model on the next falling edge. Directed checks count the same edges to pin the R5 latency, the R6 hold and the R7 back-to-back run.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;

  // Life cycle of one buffer slot
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_READY = 2'd2
  } slot_st_e;

  function automatic int unsigned tag_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rrb_ptr_ctrl.sv
`timescale 1ns/1ps
module rrb_ptr_ctrl #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned TAG_W = rrb_pkg::tag_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [TAG_W-1:0] wr_ptr,
  output logic [TAG_W-1:0] rd_ptr,
  output logic             full
);

  localparam int unsigned CNT_W = TAG_W + 1;
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt_q <= cnt_d;
      full  <= (cnt_d == CNT_W'(DEPTH));
    end
  end

endmodule

// File: rtl/rrb_slot_table.sv
`timescale 1ns/1ps
module rrb_slot_table #(
  parameter  int unsigned DEPTH  = 32,
  parameter  int unsigned META_W = 10,
  localparam int unsigned TAG_W  = rrb_pkg::tag_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  logic [META_W-1:0] alloc_meta,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_idx,
  input  logic              fill_err,
  input  logic              free_en,
  input  logic [TAG_W-1:0]  free_idx,
  output logic              fill_ok,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              head_ready,
  output logic [META_W-1:0] head_meta,
  output logic              head_err
);

  import rrb_pkg::*;

  logic [DEPTH-1:0]             wait_v;
  logic [DEPTH-1:0]             ready_v;
  logic [DEPTH-1:0]             err_v;
  logic [DEPTH-1:0][META_W-1:0] meta_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    slot_st_e          st_q;
    logic              err_q;
    logic [META_W-1:0] meta_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q  <= SLOT_FREE;
        err_q <= 1'b0;
      end else if (alloc_en && alloc_idx == TAG_W'(g)) begin
        st_q  <= SLOT_WAIT;
        err_q <= 1'b0;
      end else if (fill_en && fill_idx == TAG_W'(g)) begin
        st_q  <= SLOT_READY;
        err_q <= fill_err;
      end else if (free_en && free_idx == TAG_W'(g)) begin
        st_q  <= SLOT_FREE;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && alloc_idx == TAG_W'(g)) meta_q <= alloc_meta;
    end

    assign wait_v[g]  = (st_q == SLOT_WAIT);
    assign ready_v[g] = (st_q == SLOT_READY);
    assign err_v[g]   = err_q;
    assign meta_v[g]  = meta_q;
  end

  assign fill_ok    = wait_v[fill_idx];
  assign head_ready = ready_v[head_idx];
  assign head_meta  = meta_v[head_idx];
  assign head_err   = err_v[head_idx];

endmodule

// File: rtl/rrb_line_ram.sv
`timescale 1ns/1ps
module rrb_line_ram #(
  parameter  int unsigned DEPTH  = 32,
  parameter  int unsigned DATA_W = 1024,
  localparam int unsigned ADDR_W = rrb_pkg::tag_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rrb_reorder_buf.sv
`timescale 1ns/1ps
module rrb_reorder_buf #(
  parameter  int unsigned DEPTH    = 32,
  parameter  int unsigned DATA_W   = 1024,
  parameter  int unsigned STREAM_W = 2,
  parameter  int unsigned ID_W     = 8,
  localparam int unsigned TAG_W    = rrb_pkg::tag_bits(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_valid,
  input  logic [STREAM_W-1:0] alloc_stream,
  input  logic [ID_W-1:0]     alloc_id,
  output logic [TAG_W-1:0]    alloc_tag,
  output logic                full,
  input  logic                rsp_valid,
  input  logic [TAG_W-1:0]    rsp_tag,
  input  logic                rsp_err,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                out_valid,
  output logic [STREAM_W-1:0] out_stream,
  output logic [ID_W-1:0]     out_id,
  output logic                out_err,
  output logic [DATA_W-1:0]   out_data,
  output logic                proto_err
);

  localparam int unsigned META_W = STREAM_W + ID_W;

  logic             push, pop, fill_en, fill_ok;
  logic [TAG_W-1:0] wr_ptr, rd_ptr;
  logic             head_ready, head_err;
  logic [META_W-1:0] head_meta;

  assign push    = alloc_valid && !full;
  assign fill_en = rsp_valid && fill_ok;
  assign pop     = head_ready;

  rrb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (full)
  );

  rrb_slot_table #(.DEPTH(DEPTH), .META_W(META_W)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (push),
    .alloc_idx  (wr_ptr),
    .alloc_meta ({alloc_stream, alloc_id}),
    .fill_en    (fill_en),
    .fill_idx   (rsp_tag),
    .fill_err   (rsp_err),
    .free_en    (pop),
    .free_idx   (rd_ptr),
    .fill_ok    (fill_ok),
    .head_idx   (rd_ptr),
    .head_ready (head_ready),
    .head_meta  (head_meta),
    .head_err   (head_err)
  );

  rrb_line_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (fill_en),
    .waddr (rsp_tag),
    .wdata (rsp_data),
    .re    (pop),
    .raddr (rd_ptr),
    .rdata (out_data)
  );

  assign alloc_tag = wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_stream <= '0;
      out_id     <= '0;
      proto_err  <= 1'b0;
    end else begin
      out_valid <= pop;
      if (pop) begin
        out_err              <= head_err;
        {out_stream, out_id} <= head_meta;
      end
      if (rsp_valid && !fill_ok) proto_err <= 1'b1;
    end
  end

endmodule

// File: rtl/rrb_chk.sv
`timescale 1ns/1ps
module rrb_chk #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned TAG_W = rrb_pkg::tag_bits(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             full,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             out_valid,
  input logic             proto_err
);

  localparam int unsigned PW = TAG_W + 2;
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  // accepted requests minus beats already seen on out_valid
  logic [PW-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + PW'(alloc_valid && !full) - PW'(out_valid);
  end

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !full) |=>
      alloc_tag == (($past(alloc_tag) == LAST) ? '0 : $past(alloc_tag) + 1'b1));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && full) |=> $stable(alloc_tag));

  // R3
  full_track_chk: assert property (@(posedge clk) disable iff (rst)
    full == ((int'(pend) - int'(out_valid)) == int'(DEPTH)));

  // R4
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pend != '0);

  // R9
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

endmodule

bind rrb_reorder_buf rrb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .full        (full),
  .alloc_tag   (alloc_tag),
  .out_valid   (out_valid),
  .proto_err   (proto_err)
);

// File: tb/sim_rrb_reorder_buf.sv
`timescale 1ns/1ps
module sim_rrb_reorder_buf;

  localparam int DEPTH = 32, DATA_W = 1024, STREAM_W = 2, ID_W = 8, TAG_W = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                alloc_valid = 0, rsp_valid = 0, rsp_err = 0;
  logic [STREAM_W-1:0] alloc_stream = '0;
  logic [ID_W-1:0]     alloc_id = '0;
  logic [TAG_W-1:0]    rsp_tag = '0, alloc_tag;
  logic [DATA_W-1:0]   rsp_data = '0, out_data;
  logic                full, out_valid, out_err, proto_err;
  logic [STREAM_W-1:0] out_stream;
  logic [ID_W-1:0]     out_id;

  rrb_reorder_buf u0 (.*);

  int vectors = 0, fails = 0;
  bit live = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkdata(input int tag, input int salt);
    logic [DATA_W-1:0] d;
    for (int k = 0; k < DATA_W/32; k++)
      d[k*32 +: 32] = 32'(tag * 32'h0100_0193 + salt * 32'h9E37_79B9 + k);
    return d;
  endfunction

  // ---------------- behavioural reference model ----------------
  int                m_state [DEPTH];   // 0 free, 1 waiting, 2 holding data
  logic [DATA_W-1:0] m_data  [DEPTH];
  int                m_id    [DEPTH];
  int                m_st    [DEPTH];
  bit                m_err   [DEPTH];
  int                m_order [$];
  int                m_wr, m_t;
  bit                m_full, m_perr, m_pre_full;
  bit                e_valid, e_err;
  int                e_id, e_st;
  logic [DATA_W-1:0] e_data;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_state[i]) m_state[i] = 0;
      m_order.delete();
      m_wr = 0; m_full = 0; m_perr = 0; e_valid = 0;
    end else begin
      m_pre_full = m_full;
      e_valid = 0;
      if (m_order.size() > 0 && m_state[m_order[0]] == 2) begin
        m_t = m_order.pop_front();
        e_valid = 1; e_data = m_data[m_t]; e_id = m_id[m_t];
        e_st = m_st[m_t]; e_err = m_err[m_t];
        m_state[m_t] = 0;
      end
      if (rsp_valid) begin
        if (m_state[int'(rsp_tag)] == 1) begin
          m_state[int'(rsp_tag)] = 2;
          m_data[int'(rsp_tag)]  = rsp_data;
          m_err[int'(rsp_tag)]   = rsp_err;
        end else m_perr = 1;
      end
      if (alloc_valid && !m_pre_full) begin
        m_state[m_wr] = 1; m_id[m_wr] = int'(alloc_id); m_st[m_wr] = int'(alloc_stream);
        m_order.push_back(m_wr);
        m_wr = (m_wr + 1) % DEPTH;
      end
      m_full = (m_order.size() == DEPTH);
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      chk(out_valid == e_valid, "R4", "out_valid", longint'(out_valid), longint'(e_valid));
      if (e_valid) begin
        chk(out_data === e_data, "R5", "out_data", longint'(out_data[63:0]), longint'(e_data[63:0]));
        chk(int'(out_id) == e_id, "R5", "out_id", longint'(out_id), longint'(e_id));
        chk(int'(out_stream) == e_st, "R5", "out_stream", longint'(out_stream), longint'(e_st));
        chk(out_err == e_err, "R8", "out_err", longint'(out_err), longint'(e_err));
      end
      chk(full == m_full, "R3", "full", longint'(full), longint'(m_full));
      chk(int'(alloc_tag) == m_wr, "R2", "alloc_tag", longint'(alloc_tag), longint'(m_wr));
      chk(proto_err == m_perr, "R9", "proto_err", longint'(proto_err), longint'(m_perr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    alloc_valid = 0; rsp_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_alloc(input int id, input int st, output int tag);
    alloc_valid = 1; alloc_id = ID_W'(id); alloc_stream = STREAM_W'(st);
    rsp_valid = 0; tag = int'(alloc_tag);
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_rsp(input int tag, input bit err, input int salt);
    rsp_valid = 1; rsp_tag = TAG_W'(tag); rsp_err = err; rsp_data = mkdata(tag, salt);
    alloc_valid = 0;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1; alloc_valid = 0; rsp_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid", longint'(out_valid), 0);
    chk(full == 0, "R1", "full", longint'(full), 0);
    chk(proto_err == 0, "R1", "proto_err", longint'(proto_err), 0);
    chk(alloc_tag == 0, "R1", "alloc_tag", longint'(alloc_tag), 0);
  endtask

  int tg [40];
  int pend [$];

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int a, b, nv, ne, first, last, ntag, k;
    bit acc;
    @(negedge clk);
    do_reset();
    live = 1;

    // out-of-order fill of four slots
    for (int i = 0; i < 4; i++) begin
      do_alloc(10 + i, i, tg[i]);
      chk(tg[i] == i, "R2", "issued tag", longint'(tg[i]), longint'(i));
    end
    do_rsp(2, 0, 1);
    idle(); idle();
    chk(out_valid == 0, "R6", "younger held", longint'(out_valid), 0);
    do_rsp(0, 0, 1);
    chk(out_valid == 0, "R5", "not yet due", longint'(out_valid), 0);
    idle();
    chk(out_valid == 1 && out_id == 10, "R5", "head beat id", longint'(out_id), 10);
    do_rsp(3, 0, 1);
    do_rsp(1, 0, 1);
    for (int i = 1; i < 4; i++) begin
      idle();
      chk(out_valid == 1 && int'(out_id) == 10 + i, "R7", "back-to-back id",
          longint'(out_id), longint'(10 + i));
    end
    idle();
    chk(out_valid == 0, "R7", "run ends", longint'(out_valid), 0);

    // fill every slot, one extra request refused
    for (int i = 0; i < 33; i++) begin
      alloc_valid = 1; alloc_id = ID_W'(100 + i); alloc_stream = STREAM_W'(i);
      if (!full) tg[i] = int'(alloc_tag);
      @(negedge clk);
    end
    alloc_valid = 0;
    chk(full == 1, "R3", "full set", longint'(full), 1);
    chk(alloc_tag == 4, "R3", "tag frozen while full", longint'(alloc_tag), 4);
    nv = 0;
    for (int i = 31; i >= 0; i--) begin
      do_rsp(tg[i], (i % 5) == 0, 7);
      nv += int'(out_valid);
    end
    chk(nv == 0, "R6", "no beat before head", longint'(nv), 0);
    nv = 0; ne = 0; first = -1; last = -1;
    for (int c = 0; c < 36; c++) begin
      idle();
      if (out_valid) begin
        if (first < 0) first = c;
        last = c; nv++; ne += int'(out_err);
      end
    end
    chk(nv == 32, "R7", "beats delivered", longint'(nv), 32);
    chk(last - first == 31, "R7", "consecutive span", longint'(last - first), 31);
    chk(ne == 7, "R8", "error beats", longint'(ne), 7);

    // stray and duplicate responses
    do_rsp(7, 0, 99);
    chk(proto_err == 1, "R9", "stray tag flagged", longint'(proto_err), 1);
    chk(out_valid == 0, "R9", "stray no beat", longint'(out_valid), 0);
    idle(); idle(); idle();
    chk(proto_err == 1, "R9", "sticky", longint'(proto_err), 1);
    chk(out_valid == 0, "R9", "still no beat", longint'(out_valid), 0);
    do_alloc(50, 1, a);
    do_alloc(51, 2, b);
    do_rsp(b, 0, 200);
    do_rsp(b, 1, 201);
    do_rsp(a, 0, 202);
    idle();
    chk(out_valid == 1 && out_id == 50, "R4", "first of pair", longint'(out_id), 50);
    idle();
    chk(out_data === mkdata(b, 200), "R9", "duplicate dropped data",
        longint'(out_data[63:0]), longint'(mkdata(b, 200) ^ 0));
    chk(out_err == 0, "R9", "duplicate dropped err", longint'(out_err), 0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      acc = 0;
      alloc_valid = ($urandom % 2) == 0;
      alloc_id = ID_W'($urandom); alloc_stream = STREAM_W'($urandom);
      if (alloc_valid && !full) begin acc = 1; ntag = int'(alloc_tag); end
      rsp_valid = 0;
      if (pend.size() > 0 && ($urandom % 10) < 6) begin
        k = $urandom_range(0, pend.size() - 1);
        rsp_tag = TAG_W'(pend[k]); pend.delete(k);
        rsp_valid = 1; rsp_err = ($urandom % 8) == 0;
        rsp_data = mkdata(int'(rsp_tag), c);
      end else if (($urandom % 50) == 0) begin
        rsp_tag = TAG_W'($urandom);
        rsp_valid = 1;
        foreach (pend[j]) if (pend[j] == int'(rsp_tag)) rsp_valid = 0;
        rsp_err = 0; rsp_data = mkdata(int'(rsp_tag), c);
      end
      @(negedge clk);
      if (acc) pend.push_back(ntag);
    end
    alloc_valid = 0; rsp_valid = 0;
    while (pend.size() > 0) begin
      do_rsp(pend[0], 0, 5);
      void'(pend.pop_front());
    end
    repeat (40) idle();
    chk(full == 0, "R3", "drained", longint'(full), 0);

    live = 0;
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule